// File: doc/BRIEF.md
# Two-wire bus slave front end with general-call commands and shutdown latch

This block is the serial-bus front end of a small register-based peripheral. It watches an oversampled two-wire bus, made of a clock line and a data line, and finds START and STOP conditions. It matches a 7-bit slave address, acknowledges bytes, and turns write transfers into register writes. It serves read transfers from a simple register read port. The slave address has a fixed 6-bit prefix and one low bit. That low bit is taken from an address-select pin.

The block also answers the general-call address. The command byte that follows the general-call address can do two things: it can re-latch the address bit from the pin, or it can re-latch the bit and send a one-cycle soft-reset pulse to the rest of the device.

Software can switch the block off by writing a control register. After that, the block ignores the bus completely, and only the hardware reset input brings it back.

Top module: `i2c_gc_slave`

## Requirements
- R1: After hardware reset, SDA is released and no register strobe or soft-reset pulse is active. The address low bit is taken from `addrPin`, so the block answers address byte 0x40/0x41 with the pin at 0, and 0x42/0x43 with the pin at 1.
- R2: After START, the block receives an address byte MSB first. It pulls SDA low for the ninth (ACK) bit when bits 7:1 equal {6'b010000, address low bit}, in either direction, or when the byte is 0x00. For any other byte it returns to idle with no ACK and does not drive SDA.
- R3: In a write transfer, the first data byte becomes the register pointer. Each later byte is ACKed and written to the pointer with a one-cycle `regWrEn`, and the pointer then increments. A write strobe and a read strobe are never active together.
- R4: In a read transfer, the block drives the byte at the pointer MSB first and increments the pointer after each byte. It sends the next byte when the master ACKs, and goes idle when the master NACKs.
- R5: After a general call, a command byte of 0x06 is ACKed. It produces exactly one cycle of `softResetPulse`, re-latches the address low bit from `addrPin`, and clears the register pointer.
- R6: After a general call, a command byte of 0x04 is ACKed and re-latches the address low bit, with no soft-reset pulse.
- R7: After a general call, a command byte of 0x00, or any value other than 0x04 and 0x06, is not ACKed and changes neither the address bit, the pointer nor the pulse output. A general-call byte with the read bit set (0x01) is not ACKed.
- R8: Writing a byte with bit 0 set to register 0x0F switches the block off at the next SCL falling edge, so the ACK of that data byte still completes. While off, the block ACKs nothing, never drives SDA, issues no register strobes and ignores general-call commands. Writing 0x0F with bit 0 clear has no effect.
- R9: Only the hardware reset clears the off state. A general-call reset command sent while off does not clear it.
- R10: A repeated START at any point restarts address reception, and a STOP returns the block to idle.
- R11: SDA pull-down only starts or ends while SCL is low, and it is asserted only in ACK bits and in zero bits of read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| addrPin | input | 1 | Address-select pin giving the slave address low bit |
| regRdData | input | 8 | Register contents at `regAddr`, combinational |
| sdaPullDown | output | 1 | High to pull the data line low |
| softResetPulse | output | 1 | One-cycle reset request to the rest of the device |
| regAddr | output | 8 | Register pointer |
| regWrData | output | 8 | Byte to write |
| regWrEn | output | 1 | One-cycle register write strobe |
| regRdEn | output | 1 | One-cycle strobe when a read byte is fetched |

## Verification
Some properties are checked on every cycle. The soft-reset pulse is one cycle wide. Write and read strobes never overlap. The off state is sticky and silent, with no SDA drive and no strobes. SDA pull-down edges happen only while SCL is low. Whether an ACK is given, what data is read back, and whether each general-call command value re-latches the address bit or clears the pointer are checked only by the bench. It does this with transfers, through sweeps over every address byte and every command byte.

// File: rtl/i2c_gc_pkg.sv
package i2c_gc_pkg;

  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 7;
  localparam int CNT_W    = $clog2(BYTE_W + 1);

  localparam logic [BYTE_W-1:0] GC_ADDR_BYTE  = 8'h00;
  localparam logic [BYTE_W-1:0] GC_CMD_RESET  = 8'h06;
  localparam logic [BYTE_W-1:0] GC_CMD_LATCH  = 8'h04;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_GC_ADDR_ACK,
    ST_GC_BYTE,
    ST_GC_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK
  } ctrlState_t;

  // bus events from the sampler
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
    logic sdaBit;
  } busEvent_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic loadRd;
    logic cntClr;
    logic cntInc;
    logic ptrLoad;
    logic wrStb;
    logic ptrInc;
    logic gcReset;
    logic gcLatch;
    logic driveAck;
    logic driveData;
  } dpStrobe_t;

endpackage

// File: rtl/i2c_gc_busmon.sv
module i2c_gc_busmon
  import i2c_gc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  output busEvent_t ev
);

  localparam int LINES = 2;

  logic [LINES-1:0] lineIn;
  logic [LINES-1:0] lineNow;
  logic [LINES-1:0] linePrev;

  assign lineIn = {sdaIn, sclIn};

  // one synchroniser chain per bus line
  for (genvar g = 0; g < LINES; g++) begin : gSync
    logic [SYNC_STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= '1;
      else       pipe <= {pipe[SYNC_STAGES-2:0], lineIn[g]};
    end
    assign lineNow[g] = pipe[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) linePrev <= '1;
    else       linePrev <= lineNow;
  end

  logic sclNow, sdaNow, sclOld, sdaOld;
  assign sclNow = lineNow[0];
  assign sdaNow = lineNow[1];
  assign sclOld = linePrev[0];
  assign sdaOld = linePrev[1];

  always_comb begin
    ev.sclRise  = sclNow & ~sclOld;
    ev.sclFall  = ~sclNow & sclOld;
    ev.startDet = sclNow & sclOld & sdaOld & ~sdaNow;
    ev.stopDet  = sclNow & sclOld & ~sdaOld & sdaNow;
    ev.sdaBit   = sdaNow;
  end

endmodule

// File: rtl/i2c_gc_ctrl.sv
module i2c_gc_ctrl
  import i2c_gc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  busEvent_t         ev,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [CNT_W-1:0]  bitCnt,
  input  logic [ADDR_W-1:0] myAddr,
  input  logic              shdn,
  output dpStrobe_t         stb
);

  ctrlState_t state, nextState;
  logic readMode, nextRead;
  logic firstByte, nextFirst;
  logic masterAck, nextMAck;
  logic byteDone;

  assign byteDone = ev.sclFall && (bitCnt == CNT_W'(BYTE_W));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      readMode  <= 1'b0;
      firstByte <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state     <= nextState;
      readMode  <= nextRead;
      firstByte <= nextFirst;
      masterAck <= nextMAck;
    end
  end

  always_comb begin
    nextState = state;
    nextRead  = readMode;
    nextFirst = firstByte;
    nextMAck  = masterAck;
    stb       = '0;
    stb.driveAck  = state inside {ST_ADDR_ACK, ST_GC_ADDR_ACK, ST_WR_ACK, ST_GC_ACK};
    stb.driveData = (state == ST_RD_BYTE);

    if (shdn) begin
      nextState     = ST_IDLE;
      stb.driveAck  = 1'b0;
      stb.driveData = 1'b0;
    end else if (ev.stopDet) begin
      nextState = ST_IDLE;
    end else if (ev.startDet) begin
      nextState  = ST_ADDR;
      stb.cntClr = 1'b1;
    end else begin
      case (state)
        ST_ADDR, ST_WR_BYTE, ST_GC_BYTE: begin
          if (ev.sclRise) begin
            stb.shiftIn = 1'b1;
            stb.cntInc  = 1'b1;
          end else if (byteDone) begin
            if (state == ST_ADDR) begin
              if (rxByte[BYTE_W-1:1] == myAddr) begin
                nextState = ST_ADDR_ACK;
                nextRead  = rxByte[0];
                nextFirst = 1'b1;
              end else if (rxByte == GC_ADDR_BYTE) begin
                nextState = ST_GC_ADDR_ACK;
              end else begin
                nextState = ST_IDLE;
              end
            end else if (state == ST_WR_BYTE) begin
              if (firstByte) begin
                stb.ptrLoad = 1'b1;
                nextFirst   = 1'b0;
              end else begin
                stb.wrStb = 1'b1;
              end
              nextState = ST_WR_ACK;
            end else begin
              if (rxByte == GC_CMD_RESET) begin
                stb.gcReset = 1'b1;
                stb.gcLatch = 1'b1;
                nextState   = ST_GC_ACK;
              end else if (rxByte == GC_CMD_LATCH) begin
                stb.gcLatch = 1'b1;
                nextState   = ST_GC_ACK;
              end else begin
                nextState = ST_IDLE;
              end
            end
          end
        end
        ST_ADDR_ACK: begin
          if (ev.sclFall) begin
            if (readMode) begin
              stb.loadRd = 1'b1;
              nextState  = ST_RD_BYTE;
            end else begin
              stb.cntClr = 1'b1;
              nextState  = ST_WR_BYTE;
            end
          end
        end
        ST_GC_ADDR_ACK: begin
          if (ev.sclFall) begin
            stb.cntClr = 1'b1;
            nextState  = ST_GC_BYTE;
          end
        end
        ST_WR_ACK: begin
          if (ev.sclFall) begin
            stb.cntClr = 1'b1;
            nextState  = ST_WR_BYTE;
          end
        end
        ST_GC_ACK: begin
          if (ev.sclFall) nextState = ST_IDLE;
        end
        ST_RD_BYTE: begin
          if (ev.sclFall) begin
            if (bitCnt == CNT_W'(BYTE_W - 1)) begin
              stb.ptrInc = 1'b1;
              nextState  = ST_RD_ACK;
            end else begin
              stb.shiftOut = 1'b1;
              stb.cntInc   = 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (ev.sclRise) begin
            nextMAck = ~ev.sdaBit;
          end else if (ev.sclFall) begin
            if (masterAck) begin
              stb.loadRd = 1'b1;
              nextState  = ST_RD_BYTE;
            end else begin
              nextState = ST_IDLE;
            end
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_gc_dp.sv
module i2c_gc_dp
  import i2c_gc_pkg::*;
#(
  parameter logic [ADDR_W-2:0] ADDR_PREFIX = 6'b010000,
  parameter logic [BYTE_W-1:0] CTRL_ADDR   = 8'h0F,
  parameter int                SHDN_BIT    = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEvent_t         ev,
  input  dpStrobe_t         stb,
  input  logic              addrPin,
  input  logic [BYTE_W-1:0] regRdData,
  output logic [BYTE_W-1:0] rxByte,
  output logic [CNT_W-1:0]  bitCnt,
  output logic [ADDR_W-1:0] myAddr,
  output logic              shdnFlag,
  output logic              sdaPullDown,
  output logic              softResetPulse,
  output logic [BYTE_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              regRdEn
);

  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] ptr;
  logic              addrLsb;
  logic              pinLoad;
  logic              shdnPend;
  logic              softRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      ptr      <= '0;
      addrLsb  <= 1'b0;
      pinLoad  <= 1'b1;
      shdnPend <= 1'b0;
      shdnFlag <= 1'b0;
      softRst  <= 1'b0;
    end else begin
      softRst <= stb.gcReset;

      if (stb.loadRd)        shiftReg <= regRdData;
      else if (stb.shiftIn)  shiftReg <= {shiftReg[BYTE_W-2:0], ev.sdaBit};
      else if (stb.shiftOut) shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};

      if (stb.cntClr || stb.loadRd) bitCnt <= '0;
      else if (stb.cntInc)          bitCnt <= bitCnt + 1'b1;

      if (stb.gcReset)                ptr <= '0;
      else if (stb.ptrLoad)           ptr <= shiftReg;
      else if (stb.wrStb || stb.ptrInc) ptr <= ptr + 1'b1;

      // address bit follows the pin once after reset and on latch commands
      pinLoad <= 1'b0;
      if (pinLoad || stb.gcLatch) addrLsb <= addrPin;

      if (stb.wrStb && (ptr == CTRL_ADDR) && shiftReg[SHDN_BIT]) shdnPend <= 1'b1;
      if (shdnPend && ev.sclFall) shdnFlag <= 1'b1;
    end
  end

  assign rxByte         = shiftReg;
  assign myAddr         = {ADDR_PREFIX, addrLsb};
  assign sdaPullDown    = ~shdnFlag & (stb.driveAck | (stb.driveData & ~shiftReg[BYTE_W-1]));
  assign softResetPulse = softRst;
  assign regAddr        = ptr;
  assign regWrData      = shiftReg;
  assign regWrEn        = stb.wrStb;
  assign regRdEn        = stb.loadRd;

endmodule

// File: rtl/i2c_gc_slave.sv
module i2c_gc_slave
  import i2c_gc_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-2:0] ADDR_PREFIX = 6'b010000,
  parameter logic [BYTE_W-1:0] CTRL_ADDR   = 8'h0F,
  parameter int                SHDN_BIT    = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              addrPin,
  input  logic [BYTE_W-1:0] regRdData,
  output logic              sdaPullDown,
  output logic              softResetPulse,
  output logic [BYTE_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              regRdEn
);

  busEvent_t         ev;
  dpStrobe_t         stb;
  logic [BYTE_W-1:0] rxByte;
  logic [CNT_W-1:0]  bitCnt;
  logic [ADDR_W-1:0] myAddr;
  logic              shdnFlag;

  i2c_gc_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_busmon (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (sclIn),
    .sdaIn (sdaIn),
    .ev    (ev)
  );

  i2c_gc_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .ev     (ev),
    .rxByte (rxByte),
    .bitCnt (bitCnt),
    .myAddr (myAddr),
    .shdn   (shdnFlag),
    .stb    (stb)
  );

  i2c_gc_dp #(
    .ADDR_PREFIX (ADDR_PREFIX),
    .CTRL_ADDR   (CTRL_ADDR),
    .SHDN_BIT    (SHDN_BIT)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .ev             (ev),
    .stb            (stb),
    .addrPin        (addrPin),
    .regRdData      (regRdData),
    .rxByte         (rxByte),
    .bitCnt         (bitCnt),
    .myAddr         (myAddr),
    .shdnFlag       (shdnFlag),
    .sdaPullDown    (sdaPullDown),
    .softResetPulse (softResetPulse),
    .regAddr        (regAddr),
    .regWrData      (regWrData),
    .regWrEn        (regWrEn),
    .regRdEn        (regRdEn)
  );

endmodule

// File: rtl/i2c_gc_chk.sv
module i2c_gc_chk (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaPullDown,
  input logic softResetPulse,
  input logic regWrEn,
  input logic regRdEn,
  input logic shdnFlag
);

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    softResetPulse |=> !softResetPulse);

  assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    shdnFlag |-> (!sdaPullDown && !regWrEn && !regRdEn && !softResetPulse));

  assert_off_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    shdnFlag |=> shdnFlag);

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn));

  assert_write_one_cycle_R3: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  assert_drive_start_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullDown) |-> !sclIn);

  assert_drive_end_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaPullDown) |-> !sclIn);

endmodule

bind i2c_gc_slave i2c_gc_chk u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .sclIn          (sclIn),
  .sdaPullDown    (sdaPullDown),
  .softResetPulse (softResetPulse),
  .regWrEn        (regWrEn),
  .regRdEn        (regRdEn),
  .shdnFlag       (shdnFlag)
);

// File: tb/i2c_gc_slave_tb.sv
`timescale 1ns/1ps
module i2c_gc_slave_tb;

  localparam int Q = 4;   // quarter-bit spacing in clocks

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic rstN, sclDrv, sdaDrv, addrPin;
  logic [7:0] regRdData, regAddr, regWrData;
  logic sdaPullDown, softResetPulse, regWrEn, regRdEn;
  logic sdaLine;

  assign sdaLine = sdaDrv & ~sdaPullDown;

  logic [7:0] mem [0:255];
  assign regRdData = mem[regAddr];

  int pulseCnt = 0;
  int wrCnt    = 0;
  int pdCnt    = 0;
  logic offWin = 1'b0;

  always @(posedge clk) begin
    if (regWrEn) begin
      mem[regAddr] <= regWrData;
      wrCnt <= wrCnt + 1;
    end
    if (softResetPulse) pulseCnt <= pulseCnt + 1;
    if (offWin && sdaPullDown) pdCnt <= pdCnt + 1;
  end

  i2c_gc_slave u_dut (
    .clk            (clk),
    .rstN           (rstN),
    .sclIn          (sclDrv),
    .sdaIn          (sdaLine),
    .addrPin        (addrPin),
    .regRdData      (regRdData),
    .sdaPullDown    (sdaPullDown),
    .softResetPulse (softResetPulse),
    .regAddr        (regAddr),
    .regWrData      (regWrData),
    .regWrEn        (regWrEn),
    .regRdEn        (regRdEn)
  );

  int vecCnt  = 0;
  int failCnt = 0;

  task automatic chk(input string req, input int act, input int exp);
    vecCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset(input logic pin);
    rstN = 1'b0; addrPin = pin; sclDrv = 1'b1; sdaDrv = 1'b1;
    waitQ(5);
    rstN = 1'b1;
    waitQ(5);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; waitQ(Q);
    sclDrv = 1'b1; waitQ(Q);
    sdaDrv = 1'b0; waitQ(Q);
    sclDrv = 1'b0; waitQ(Q);
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; waitQ(Q);
    sclDrv = 1'b1; waitQ(Q);
    sdaDrv = 1'b1; waitQ(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = b[i]; waitQ(Q);
      sclDrv = 1'b1; waitQ(Q);
      sclDrv = 1'b0; waitQ(Q);
    end
    sdaDrv = 1'b1; waitQ(Q);
    sclDrv = 1'b1; waitQ(Q/2);
    acked = ~sdaLine;
    waitQ(Q/2);
    sclDrv = 1'b0; waitQ(Q);
  endtask

  task automatic readByte(output logic [7:0] b, input logic mAck);
    sdaDrv = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      waitQ(Q);
      sclDrv = 1'b1; waitQ(Q/2);
      b = {b[6:0], sdaLine};
      waitQ(Q/2);
      sclDrv = 1'b0; waitQ(Q);
    end
    sdaDrv = ~mAck; waitQ(Q);
    sclDrv = 1'b1; waitQ(Q);
    sclDrv = 1'b0; waitQ(Q);
    sdaDrv = 1'b1;
  endtask

  // address-only probe; reads one byte with NACK if a read is acknowledged
  task automatic probe(input logic [7:0] a, output logic acked);
    logic [7:0] dummy;
    busStart();
    sendByte(a, acked);
    if (acked && a[0]) readByte(dummy, 1'b0);
    busStop();
  endtask

  task automatic gcCmd(input logic [7:0] cmd, output logic ackA, output logic ackC);
    busStart();
    sendByte(8'h00, ackA);
    sendByte(cmd, ackC);
    busStop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    vecCnt++;
    failCnt++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

  initial begin
    logic ack, ack2;
    logic [7:0] rd;
    int pBefore, wBefore;

    doReset(1'b0);
    // R1: idle outputs after reset
    chk("R1 idle outputs", {sdaPullDown, softResetPulse, regWrEn, regRdEn}, 0);

    // R2: sweep every address byte, pin low -> 0x40/0x41 and 0x00 acked
    for (int b = 0; b < 256; b++) begin
      probe(8'(b), ack);
      chk($sformatf("R2 addr %02h", b), int'(ack),
          int'(((b >> 1) == 'h20) || (b == 0)));
    end

    // R3: pointer then burst of writes
    busStart();
    sendByte(8'h40, ack);
    sendByte(8'h00, ack2);
    chk("R3 ptr ack", int'(ack & ack2), 1);
    sendByte(8'h5A, ack);
    chk("R3 data ack", int'(ack), 1);
    busStop();
    busStart();
    sendByte(8'h40, ack);
    sendByte(8'h10, ack);
    for (int i = 0; i < 16; i++) begin
      sendByte(8'((i * 37) ^ 8'h3C), ack);
      chk("R3 burst ack", int'(ack), 1);
    end
    busStop();
    chk("R3 mem 00", int'(mem[0]), 'h5A);
    for (int i = 0; i < 16; i++)
      chk($sformatf("R3 mem %02h", 16 + i), int'(mem[16 + i]), int'(8'((i * 37) ^ 8'h3C)));

    // R4 / R10: pointer set, repeated START, burst read
    busStart();
    sendByte(8'h40, ack);
    sendByte(8'h10, ack);
    busStart();
    sendByte(8'h41, ack);
    chk("R10 repeated start ack", int'(ack), 1);
    for (int i = 0; i < 16; i++) begin
      readByte(rd, (i != 15));
      chk($sformatf("R4 read %0d", i), int'(rd), int'(8'((i * 37) ^ 8'h3C)));
    end
    busStop();
    probe(8'h40, ack);
    chk("R4 idle after nack", int'(ack), 1);

    // R6: latch command with pin high
    addrPin = 1'b1;
    pBefore = pulseCnt;
    gcCmd(8'h04, ack, ack2);
    chk("R6 gc addr ack", int'(ack), 1);
    chk("R6 cmd ack", int'(ack2), 1);
    chk("R6 no pulse", pulseCnt, pBefore);
    probe(8'h42, ack);
    chk("R6 new addr", int'(ack), 1);
    probe(8'h40, ack);
    chk("R6 old addr", int'(ack), 0);

    // R5: reset command with pin low
    addrPin = 1'b0;
    pBefore = pulseCnt;
    gcCmd(8'h06, ack, ack2);
    chk("R5 cmd ack", int'(ack & ack2), 1);
    chk("R5 one pulse cycle", pulseCnt, pBefore + 1);
    probe(8'h42, ack);
    chk("R5 old addr", int'(ack), 0);
    busStart();
    sendByte(8'h41, ack);
    chk("R5 relatched addr", int'(ack), 1);
    readByte(rd, 1'b0);
    busStop();
    chk("R5 pointer cleared", int'(rd), 'h5A);

    // R7: every other command value is refused and inert
    addrPin = 1'b1;
    pBefore = pulseCnt;
    for (int v = 0; v < 256; v++) begin
      if (v == 4 || v == 6) continue;
      gcCmd(8'(v), ack, ack2);
      chk($sformatf("R7 cmd %02h", v), int'({ack, ack2}), 2);
    end
    chk("R7 no pulse", pulseCnt, pBefore);
    probe(8'h40, ack);
    chk("R7 addr kept", int'(ack), 1);
    addrPin = 1'b0;

    // R8: control write with bit 0 clear is harmless
    busStart();
    sendByte(8'h40, ack);
    sendByte(8'h0F, ack);
    sendByte(8'hFE, ack);
    busStop();
    probe(8'h40, ack);
    chk("R8 clear bit no effect", int'(ack), 1);

    // R8: switch off; data byte ack still completes
    busStart();
    sendByte(8'h40, ack);
    sendByte(8'h0F, ack);
    sendByte(8'h01, ack);
    chk("R8 final ack", int'(ack), 1);
    busStop();
    offWin = 1'b1;
    wBefore = wrCnt;
    pBefore = pulseCnt;
    probe(8'h40, ack);
    chk("R8 off write addr", int'(ack), 0);
    probe(8'h41, ack);
    chk("R8 off read addr", int'(ack), 0);
    gcCmd(8'h06, ack, ack2);
    chk("R8 off gc", int'({ack, ack2}), 0);
    busStart();
    sendByte(8'h40, ack);
    sendByte(8'h20, ack);
    sendByte(8'h77, ack);
    busStop();
    chk("R8 no writes", wrCnt, wBefore);
    chk("R8 no pulse", pulseCnt, pBefore);
    chk("R8 never drove SDA", pdCnt, 0);

    // R9: still off after a reset command; hardware reset revives it
    probe(8'h40, ack);
    chk("R9 still off", int'(ack), 0);
    offWin = 1'b0;
    doReset(1'b1);
    probe(8'h42, ack);
    chk("R9 R1 alive with pin high", int'(ack), 1);
    busStart();
    sendByte(8'h42, ack);
    sendByte(8'h20, ack);
    sendByte(8'h99, ack);
    busStop();
    chk("R9 write after reset", int'(mem[8'h20]), 'h99);

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

endmodule